// File: doc/BRIEF.md
# Hundredths-Resolution Clock Calendar

This block is a synchronous timekeeping core. It runs from a clock enable that pulses once per oscillator period (nominally 32,768 per second). A fractional accumulator turns that rate into exactly one hundred centisecond steps per second. The steps ripple through a carry chain: centiseconds, seconds, minutes, hours, day of month, month and a two-digit year counted from 2000. A day-of-week counter moves with the day. February gets its leap day without any help from the host.

A host loads any field through a one-cycle write port and reads any field through a registered read port. A vector of per-field strobes marks each field that the counting logic has just moved, so that alarm comparison logic placed beside the core only needs to act on those cycles. A single output pin can carry a 1 Hz or 100 Hz square wave, a copy of the oscillator enable, or an external interrupt request.

Top module: `rtc_calendar_core`

## Requirements
- R1: Starting from a cleared accumulator, N oscillator ticks advance the centisecond field floor(N*CS_PER_SEC/TICK_HZ) times. One second of ticks therefore gives exactly CS_PER_SEC steps.
- R2: The centisecond field counts 0..CS_PER_SEC-1, seconds and minutes count 0..59, and hours count 0..23. Each field returns to 0 and carries into the next one when it passes its top value.
- R3: At the end of a month the day field returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, and months 1, 3, 5, 7, 8, 10 and 12 have 31.
- R4: February has 29 days when the year field is a multiple of 4 (year 00 included), and 28 days otherwise.
- R5: After month 12 the month becomes 1 and the year advances. Year 99 wraps to 00.
- R6: The day-of-week field counts 0..6 and advances in the same cycle as the day of month, wrapping from 6 to 0.
- R7: A write with wr_en high loads wr_data into the field chosen by wr_addr (0 centiseconds, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 day of week) and clears the fractional accumulator.
- R8: In a cycle with wr_en high, no field counts. A centisecond step due in that cycle is dropped, and chg is all zero in the next cycle.
- R9: rd_data shows the field chosen by rd_addr (same map as R7) one clock after rd_addr is presented.
- R10: chg bit i (same index as R7) is high for one cycle exactly when field i has just been moved by counting. Writes raise no bit.
- R11: fout is registered one cycle after its source. fsel 0 passes irq_in. fsel 1 is high while centiseconds < CS_PER_SEC/2. fsel 2 is high while the accumulator is below TICK_HZ/2 (first half of each centisecond). fsel 3 copies tick_en.
- R12: After reset, the fields hold 00:00:00.00 on day 1, month 1, year 00, weekday 0, with chg and fout low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field selected for writing |
| wr_data | input | 8 | Binary value to load |
| rd_addr | input | 3 | Field selected for reading |
| rd_data | output | 8 | Registered value of the selected field |
| chg | output | 8 | Per-field counting strobes |
| fsel | input | 2 | Output pin source select |
| irq_in | input | 1 | Interrupt request passed to fout in mode 0 |
| fout | output | 1 | Frequency or interrupt output |

## Verification
A host write and a counting step can land on the same clock edge. The bench forces this by loading 23:59:59.99 and ticking twice, so that a centisecond step is pending, then writing the minutes field on the very edge where that step would apply. It then expects the seconds to still read 59, no change strobes, and the new minute value. It also expects that two further ticks produce exactly one step, which proves the accumulator was cleared instead of left partly full.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int FW     = 8;
  localparam int NFIELD = 8;

  typedef enum logic [2:0] {
    F_CS    = 3'd0,
    F_SEC   = 3'd1,
    F_MIN   = 3'd2,
    F_HOUR  = 3'd3,
    F_DATE  = 3'd4,
    F_MONTH = 3'd5,
    F_YEAR  = 3'd6,
    F_DOW   = 3'd7
  } field_e;

  typedef enum logic [1:0] {
    FO_IRQ   = 2'd0,
    FO_1HZ   = 2'd1,
    FO_100HZ = 2'd2,
    FO_OSC   = 2'd3
  } fsel_e;

  // Days in a month; years are offsets from 2000, so every multiple of 4 is leap up to 2099
  function automatic logic [FW-1:0] month_days(input logic [FW-1:0] month,
                                               input logic [FW-1:0] year);
    logic [FW-1:0] d;
    case (month)
      8'd2:                    d = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
      default:                 d = 8'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int TICK_HZ    = 32768,
  parameter int CS_PER_SEC = 100,
  localparam int ACC_W     = $clog2(TICK_HZ + CS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             clr,
  output logic [ACC_W-1:0] acc,
  output logic             cs_pulse
);

  logic [ACC_W-1:0] sum;
  logic             wrap;
  logic [ACC_W-1:0] acc_nxt;

  always_comb begin
    sum     = acc + ACC_W'(CS_PER_SEC);
    wrap    = (sum >= ACC_W'(TICK_HZ));
    acc_nxt = wrap ? (sum - ACC_W'(TICK_HZ)) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc      <= '0;
      cs_pulse <= 1'b0;
    end else if (tick_en) begin
      acc      <= acc_nxt;
      cs_pulse <= wrap;
    end else begin
      cs_pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int CS_PER_SEC = 100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_pulse,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_addr,
  input  logic [FW-1:0]              wr_data,
  output logic [NFIELD-1:0][FW-1:0]  fld_q,
  output logic [NFIELD-1:0]          chg_q
);

  logic [NFIELD-1:0][FW-1:0] hi;
  logic [NFIELD-1:0][FW-1:0] lo;
  logic [NFIELD-1:0][FW-1:0] nxt;
  logic [NFIELD-1:0]         at_hi;
  logic [NFIELD-1:0]         step;
  logic                      base;

  // A write cycle suppresses every count step
  assign base = cs_pulse & ~wr_en;

  always_comb begin
    hi          = '0;
    lo          = '0;
    hi[F_CS]    = FW'(CS_PER_SEC - 1);
    hi[F_SEC]   = 8'd59;
    hi[F_MIN]   = 8'd59;
    hi[F_HOUR]  = 8'd23;
    hi[F_DATE]  = month_days(fld_q[F_MONTH], fld_q[F_YEAR]);
    hi[F_MONTH] = 8'd12;
    hi[F_YEAR]  = 8'd99;
    hi[F_DOW]   = 8'd6;
    lo[F_DATE]  = 8'd1;
    lo[F_MONTH] = 8'd1;
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    // Weekday steps on the same condition as the day of month
    localparam int CH = (i == int'(F_DOW)) ? int'(F_DATE) : i;
    localparam logic [NFIELD-1:0] MASK = NFIELD'((1 << CH) - 1);
    assign at_hi[i] = (fld_q[i] >= hi[i]);
    assign step[i]  = base & (&(at_hi | ~MASK));
    assign nxt[i]   = step[i] ? (at_hi[i] ? lo[i] : fld_q[i] + 8'd1) : fld_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q          <= '0;
      fld_q[F_DATE]  <= 8'd1;
      fld_q[F_MONTH] <= 8'd1;
      chg_q          <= '0;
    end else if (wr_en) begin
      fld_q[wr_addr] <= wr_data;
      chg_q          <= '0;
    end else begin
      fld_q <= nxt;
      chg_q <= step;
    end
  end

endmodule

// File: rtl/rtc_freq_out.sv
module rtc_freq_out
  import rtc_cal_pkg::*;
#(
  parameter int TICK_HZ    = 32768,
  parameter int CS_PER_SEC = 100,
  localparam int ACC_W     = $clog2(TICK_HZ + CS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fsel,
  input  logic             irq_in,
  input  logic             tick_en,
  input  logic [FW-1:0]    cs,
  input  logic [ACC_W-1:0] acc,
  output logic             fout
);

  logic src;

  always_comb begin
    case (fsel_e'(fsel))
      FO_1HZ:   src = (cs < FW'(CS_PER_SEC / 2));
      FO_100HZ: src = (acc < ACC_W'(TICK_HZ / 2));
      FO_OSC:   src = tick_en;
      default:  src = irq_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) fout <= 1'b0;
    else     fout <= src;
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int TICK_HZ    = 32768,
  parameter int CS_PER_SEC = 100,
  localparam int ACC_W     = $clog2(TICK_HZ + CS_PER_SEC)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [7:0] chg,
  input  logic [1:0] fsel,
  input  logic       irq_in,
  output logic       fout
);

  logic [ACC_W-1:0]          sub_acc;
  logic                      cs_pulse;
  logic [NFIELD-1:0][FW-1:0] fld;
  logic [NFIELD-1:0]         chg_w;

  rtc_subsec #(.TICK_HZ(TICK_HZ), .CS_PER_SEC(CS_PER_SEC)) u_subsec (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .clr      (wr_en),
    .acc      (sub_acc),
    .cs_pulse (cs_pulse)
  );

  rtc_calendar #(.CS_PER_SEC(CS_PER_SEC)) u_cal (
    .clk      (clk),
    .rst      (rst),
    .cs_pulse (cs_pulse),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .fld_q    (fld),
    .chg_q    (chg_w)
  );

  rtc_freq_out #(.TICK_HZ(TICK_HZ), .CS_PER_SEC(CS_PER_SEC)) u_fout (
    .clk     (clk),
    .rst     (rst),
    .fsel    (fsel),
    .irq_in  (irq_in),
    .tick_en (tick_en),
    .cs      (fld[F_CS]),
    .acc     (sub_acc),
    .fout    (fout)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= fld[rd_addr];
  end

  assign chg = chg_w;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
  parameter int ACC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [7:0]        chg,
  input logic [7:0][7:0]   fld,
  input logic [ACC_W-1:0]  acc
);

  // R8: a write cycle produces no counting strobe
  a_r8_write_blocks_count: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (chg == 8'h00));

  // R7: a write empties the fractional accumulator
  a_r7_write_clears_acc: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (acc == '0));

  // R6: weekday and day of month move together
  a_r6_dow_with_date: assert property (@(posedge clk) disable iff (rst)
    chg[4] |-> chg[7]);

  a_r6_date_with_dow: assert property (@(posedge clk) disable iff (rst)
    chg[7] |-> chg[4]);

  // R3: a day wrap to 1 comes with a month step
  a_r3_month_on_date_wrap: assert property (@(posedge clk) disable iff (rst)
    (chg[4] && fld[4] == 8'd1) |-> chg[5]);

  // R2: a seconds step only follows a centisecond wrap to zero
  a_r2_sec_on_cs_wrap: assert property (@(posedge clk) disable iff (rst)
    chg[1] |-> (chg[0] && fld[0] == 8'd0));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.ACC_W(ACC_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .chg   (chg_w),
  .fld   (fld),
  .acc   (sub_acc)
);

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;

  localparam int HZ = 128;
  localparam int CS = 100;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick_en;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] chg;
  logic [1:0] fsel;
  logic       irq_in;
  logic       fout;

  int n_chk  = 0;
  int n_fail = 0;
  int chg_cnt [8];
  int m [8];

  always #4 clk = ~clk;

  rtc_calendar_core #(.TICK_HZ(HZ), .CS_PER_SEC(CS)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .chg(chg),
    .fsel(fsel), .irq_in(irq_in), .fout(fout)
  );

  always @(negedge clk)
    if (!rst)
      for (int i = 0; i < 8; i++) if (chg[i]) chg_cnt[i]++;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m[0]++;
    if (m[0] >= CS) begin
      m[0] = 0; m[1]++;
      if (m[1] >= 60) begin
        m[1] = 0; m[2]++;
        if (m[2] >= 60) begin
          m[2] = 0; m[3]++;
          if (m[3] >= 24) begin
            m[3] = 0; m[7] = (m[7] + 1) % 7; m[4]++;
            if (m[4] > dim(m[5], m[6])) begin
              m[4] = 1; m[5]++;
              if (m[5] > 12) begin m[5] = 1; m[6] = (m[6] + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < 8; i++) chg_cnt[i] = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int cs, input int s, input int mi, input int h,
                      input int d, input int mo, input int y, input int w);
    m[0] = cs; m[1] = s; m[2] = mi; m[3] = h; m[4] = d; m[5] = mo; m[6] = y; m[7] = w;
    for (int f = 0; f < 8; f++) wr(f, m[f]);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < (n * CS) / HZ; k++) model_step();
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic check_all(input string req);
    int v;
    for (int f = 0; f < 8; f++) begin
      rd(f, v);
      check($sformatf("%s field %0d", req, f), v, m[f]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v;
    rst = 1'b1; tick_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; fsel = 2'd0; irq_in = 1'b0;
    clr_cnt();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 0; m[4] = 1; m[5] = 1; m[6] = 0; m[7] = 0;
    check_all("R12 reset");
    check("R12 chg after reset", int'(chg), 0);
    check("R12 fout after reset", int'(fout), 0);

    // R7/R9 writes land in the addressed field; R10 writes raise no strobes
    clr_cnt();
    load(42, 17, 33, 9, 15, 7, 45, 2);
    check_all("R7 R9 load");
    check("R10 write strobes", chg_cnt[0] + chg_cnt[1] + chg_cnt[4], 0);

    // R1/R10 three seconds of ticks give 300 centisecond steps and 3 second steps
    load(0, 56, 34, 12, 10, 3, 20, 1);
    clr_cnt();
    run(HZ * 3);
    check("R1 cs strobes per 3 s", chg_cnt[0], 3 * CS);
    check("R10 sec strobes", chg_cnt[1], 3);
    check("R10 min strobes", chg_cnt[2], 0);
    check_all("R1 R2 after 3 s");

    // R1 partial run: 50 ticks give floor(5000/128)=39 steps
    load(0, 0, 0, 0, 1, 1, 0, 0);
    run(50);
    check_all("R1 fractional 50 ticks");

    // R2 carry over a minute boundary
    load(50, 30, 59, 23, 28, 6, 10, 4);
    run(HZ * 31);
    check_all("R2 minute and hour carry");

    // R3 R4 R5 R6 month-end sweep over leap and common years
    for (int yi = 0; yi < 2; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int y;
        y = (yi == 0) ? 23 : 24;
        load(99, 59, 59, 23, dim(mo, y), mo, y, mo % 7);
        run(2);
        check_all($sformatf("R3 R4 R5 R6 end of month %0d year %0d", mo, y));
        check("R3 day wraps to 1", m[4], 1);
      end
    end

    // R4 Feb 28 in leap year 00 goes to 29
    load(99, 59, 59, 23, 28, 2, 0, 6);
    run(2);
    check_all("R4 year 00 leap day");
    // R6 weekday wrapped 6 -> 0
    check("R6 weekday wrap", m[7], 0);

    // R5 year 99 wraps to 00
    load(99, 59, 59, 23, 31, 12, 99, 3);
    run(2);
    check_all("R5 year 99 wrap");

    // R8 write on the same edge as a pending centisecond step
    load(99, 59, 59, 23, 10, 5, 30, 2);
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clr_cnt();
    tick_en = 1'b0; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'd5;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 no strobe in collision", chg_cnt[0] + chg_cnt[1], 0);
    m[2] = 5;
    check_all("R8 write wins");
    run(2);
    check_all("R8 R7 accumulator cleared");

    // R11 output modes
    irq_in = 1'b1; fsel = 2'd0;
    repeat (2) @(negedge clk);
    check("R11 irq pass high", int'(fout), 1);
    irq_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 irq pass low", int'(fout), 0);
    fsel = 2'd1;
    wr(0, 30);
    repeat (2) @(negedge clk);
    check("R11 1Hz high half", int'(fout), 1);
    wr(0, 70);
    repeat (2) @(negedge clk);
    check("R11 1Hz low half", int'(fout), 0);
    fsel = 2'd2;
    repeat (2) @(negedge clk);
    check("R11 100Hz acc zero", int'(fout), 1);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 100Hz acc past half", int'(fout), 0);
    fsel = 2'd3;
    repeat (2) @(negedge clk);
    check("R11 osc idle", int'(fout), 0);
    tick_en = 1'b1;
    @(negedge clk);
    check("R11 osc follows tick", int'(fout), 1);
    tick_en = 1'b0;
    @(negedge clk);
    check("R11 osc tick ends", int'(fout), 0);

    summary();
    $finish;
  end

endmodule